// File: doc/BRIEF.md
# Science Mode Selector with Hysteresis

This block chooses which of four data-collection modes an instrument runs in: slow survey, fast survey, particle burst or wave burst. It watches an 8-bit trigger evaluation value that arrives with a valid strobe at a slow periodic rate. It compares each sample against two commanded thresholds, one for particle burst and one for wave burst, and climbs or descends one mode at a time. How the trigger value is computed is outside this block.

Leaving slow survey takes an explicit command. Once in fast survey, samples that exceed a threshold strictly move the block up a level. A burst mode steps back down one level in either of two cases: a sample falls to or below seven eighths of that mode's threshold, or the burst memory allocation reports full. The gap between the climb level and the release level is the hysteresis that stops the block from chattering around a threshold. A return-to-slow command overrides everything else from any mode.

Top module: `sms_mode_sel`

## Requirements
- R1: While reset is asserted, and after it is released, the mode output reads slow survey. Mode encoding: 0 = slow survey, 1 = fast survey, 2 = particle burst, 3 = wave burst.
- R2: In slow survey the trigger value is ignored. Only the go-fast command moves the block to fast survey, on the next clock edge.
- R3: In fast survey, a valid sample strictly greater than the particle-burst threshold moves the block to particle burst. A sample equal to the threshold does not.
- R4: In particle burst, a valid sample strictly greater than the wave-burst threshold moves the block to wave burst. This check takes priority over the release check of R5.
- R5: In particle burst, a valid sample at or below pb - (pb >> 3), where pb is the particle-burst threshold, returns the block to fast survey.
- R6: In wave burst, a valid sample at or below wb - (wb >> 3), where wb is the wave-burst threshold, returns the block to particle burst.
- R7: Memory-full in particle burst or wave burst steps the block down one level on the next edge, whether or not a sample is valid, and wins over any sample in the same cycle. In slow survey and fast survey it has no effect.
- R8: The go-slow command returns the block to slow survey on the next edge from any mode. It takes priority over every other input.
- R9: If no sample is valid and neither command nor memory-full is asserted, the mode holds. Outside slow survey the go-fast command is ignored.
- R10: The mode moves by at most one level per clock, except on a go-slow command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| eval_val | input | 8 | Trigger evaluation value, 0 to 255 |
| eval_vld | input | 1 | One-cycle strobe marking a new evaluation value |
| pb_thresh | input | 8 | Particle-burst threshold |
| wb_thresh | input | 8 | Wave-burst threshold |
| go_fast | input | 1 | Command: leave slow survey for fast survey |
| go_slow | input | 1 | Command: return to slow survey from any mode |
| mem_full | input | 1 | Burst memory allocation exhausted |
| mode | output | 2 | Current mode (0 slow, 1 fast, 2 particle, 3 wave) |

## Verification
Two things can land in the same cycle: a valid evaluation sample, and an immediate step-down from memory-full (or a go-slow command). The bench starts the block from each of the four modes. For every evaluation value from 0 to 255, it applies the sample both alone and together with memory-full, over several threshold pairs. These include zero thresholds, near-maximum thresholds and a wave threshold below the particle threshold. Each result is compared with a next mode computed arithmetically from the stated priorities: go-slow first, then memory-full, then strict-greater escalation, then the seven-eighths release.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [1:0] {
    MODE_SLOW = 2'd0,
    MODE_FAST = 2'd1,
    MODE_PART = 2'd2,
    MODE_WAVE = 2'd3
  } sms_mode_e;
endpackage

// File: rtl/sms_release.sv
// Release level of a threshold: thr - (thr >> SHIFT), i.e. thr reduced by 1/2^SHIFT.
module sms_release #(
  parameter int W     = 8,
  parameter int SHIFT = 3
) (
  input  logic [W-1:0] thr,
  output logic [W-1:0] rel
);
  always_comb begin
    rel = thr - (thr >> SHIFT);
  end
endmodule

// File: rtl/sms_level_cmp.sv
// Per-level comparator: strict-greater climb flag and at-or-below release flag.
module sms_level_cmp #(
  parameter int W     = 8,
  parameter int SHIFT = 3
) (
  input  logic [W-1:0] eval_val,
  input  logic [W-1:0] thr,
  output logic         above,
  output logic         below
);
  logic [W-1:0] rel_lvl;

  sms_release #(.W(W), .SHIFT(SHIFT)) u_rel (
    .thr (thr),
    .rel (rel_lvl)
  );

  always_comb begin
    above = (eval_val > thr);
    below = (eval_val <= rel_lvl);
  end
endmodule

// File: rtl/sms_next_state.sv
// Next-mode decision. Priority: go_slow, mem_full, go_fast (slow only), sample.
module sms_next_state
  import sms_pkg::*;
(
  input  sms_mode_e  cur,
  input  logic [1:0] above,    // [0] particle level, [1] wave level
  input  logic [1:0] below,
  input  logic       eval_vld,
  input  logic       mem_full,
  input  logic       go_slow,
  input  logic       go_fast,
  output sms_mode_e  nxt
);
  always_comb begin
    nxt = cur;
    if (go_slow) begin
      nxt = MODE_SLOW;
    end else begin
      unique case (cur)
        MODE_SLOW: begin
          if (go_fast) nxt = MODE_FAST;
        end
        MODE_FAST: begin
          if (eval_vld && above[0]) nxt = MODE_PART;
        end
        MODE_PART: begin
          if (mem_full)                    nxt = MODE_FAST;
          else if (eval_vld && above[1])   nxt = MODE_WAVE;
          else if (eval_vld && below[0])   nxt = MODE_FAST;
        end
        MODE_WAVE: begin
          if (mem_full)                    nxt = MODE_PART;
          else if (eval_vld && below[1])   nxt = MODE_PART;
        end
        default: nxt = MODE_SLOW;
      endcase
    end
  end
endmodule

// File: rtl/sms_mode_sel.sv
module sms_mode_sel
  import sms_pkg::*;
#(
  parameter int EVAL_W    = 8,
  parameter int REL_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVAL_W-1:0] eval_val,
  input  logic              eval_vld,
  input  logic [EVAL_W-1:0] pb_thresh,
  input  logic [EVAL_W-1:0] wb_thresh,
  input  logic              go_fast,
  input  logic              go_slow,
  input  logic              mem_full,
  output logic [1:0]        mode
);
  localparam int LEVELS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // per-level comparisons
  logic [LEVELS-1:0][EVAL_W-1:0] thr_lvl;
  logic [LEVELS-1:0]             above_lvl;
  logic [LEVELS-1:0]             below_lvl;

  assign thr_lvl[0] = pb_thresh;
  assign thr_lvl[1] = wb_thresh;

  for (genvar gi = 0; gi < LEVELS; gi++) begin : g_lvl
    sms_level_cmp #(.W(EVAL_W), .SHIFT(REL_SHIFT)) u_cmp (
      .eval_val (eval_val),
      .thr      (thr_lvl[gi]),
      .above    (above_lvl[gi]),
      .below    (below_lvl[gi])
    );
  end

  // next state
  sms_mode_e mode_q;
  sms_mode_e mode_d;
  logic      mode_en;

  sms_next_state u_nxt (
    .cur      (mode_q),
    .above    (above_lvl),
    .below    (below_lvl),
    .eval_vld (eval_vld),
    .mem_full (mem_full),
    .go_slow  (go_slow),
    .go_fast  (go_fast),
    .nxt      (mode_d)
  );

  assign mode_en = eval_vld | mem_full | go_slow | go_fast;

  // register
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     mode_q <= MODE_SLOW;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/sms_mode_chk.sv
module sms_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       eval_vld,
  input logic       mem_full,
  input logic       go_slow,
  input logic       go_fast
);
  // R8
  go_slow_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_slow |=> (mode == 2'd0));

  // R2
  slow_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !go_fast && !go_slow) |=> (mode == 2'd0));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_vld && !mem_full && !go_slow && !go_fast) |=> $stable(mode));

  // R7
  wave_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && mem_full && !go_slow) |=> (mode == 2'd2));

  // R7
  part_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && mem_full && !go_slow) |=> (mode == 2'd1));

  // R10
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !go_slow) |=> (mode != 2'd3));
endmodule

bind sms_mode_sel sms_mode_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .mode     (mode_q),
  .eval_vld (eval_vld),
  .mem_full (mem_full),
  .go_slow  (go_slow),
  .go_fast  (go_fast)
);

// File: tb/sms_mode_sel_test.sv
`timescale 1ns/1ps
module sms_mode_sel_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] eval_val;
  logic       eval_vld;
  logic [7:0] pb_thresh;
  logic [7:0] wb_thresh;
  logic       go_fast;
  logic       go_slow;
  logic       mem_full;
  logic [1:0] mode;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  sms_mode_sel uut (
    .clk(clk), .rst_n(rst_n), .eval_val(eval_val), .eval_vld(eval_vld),
    .pb_thresh(pb_thresh), .wb_thresh(wb_thresh), .go_fast(go_fast),
    .go_slow(go_slow), .mem_full(mem_full), .mode(mode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: mode=%0d expected=%0d (pb=%0d wb=%0d ev=%0d)",
               req, act, exp, pb_thresh, wb_thresh, eval_val);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // expected next mode from the stated priorities
  function automatic int exp_mode(int m, int ev, int pb, int wb,
                                  bit vld, bit mf, bit gs, bit gf);
    if (gs) return 0;
    if (mf && m >= 2) return m - 1;
    if (m == 0) return gf ? 1 : 0;
    if (!vld) return m;
    if (m == 1) return (ev > pb) ? 2 : 1;
    if (m == 2) begin
      if (ev > wb) return 3;
      if (ev <= pb - pb / 8) return 1;
      return 2;
    end
    return (ev <= wb - wb / 8) ? 2 : 3;
  endfunction

  function automatic string req_of(int m, bit mf);
    if (mf && m >= 2) return "R7";
    case (m)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  task automatic clear_in();
    eval_vld = 1'b0; go_fast = 1'b0; go_slow = 1'b0; mem_full = 1'b0;
  endtask

  // drive the block into mode m (thresholds must be below 255)
  task automatic reach(int m);
    clear_in();
    go_slow = 1'b1; tick(); go_slow = 1'b0;
    if (m >= 1) begin go_fast = 1'b1; tick(); go_fast = 1'b0; end
    if (m >= 2) begin eval_val = 8'd255; eval_vld = 1'b1; tick(); end
    if (m >= 3) tick();
    eval_vld = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, mode=%0d expected=done", mode);
    finish_run();
  end

  initial begin
    int pbs[6] = '{100, 0, 254, 8, 37, 64};
    int wbs[6] = '{200, 0, 254, 7, 150, 64};
    rst_n = 1'b0; eval_val = '0; pb_thresh = '0; wb_thresh = '0;
    clear_in();
    repeat (3) tick();
    check("R1 in reset", mode, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 after release", mode, 0);

    // R9: idle and go_fast outside slow
    pb_thresh = 8'd100; wb_thresh = 8'd200;
    reach(2);
    repeat (5) tick();
    check("R9 idle hold", mode, 2);
    go_fast = 1'b1; tick(); go_fast = 1'b0;
    check("R9 go_fast ignored", mode, 2);
    // R9: sample present but not valid
    eval_val = 8'd0; tick();
    check("R9 invalid sample", mode, 2);

    // R8: go_slow with every other input in wave burst
    reach(3);
    eval_val = 8'd255; eval_vld = 1'b1; mem_full = 1'b1; go_fast = 1'b1;
    go_slow = 1'b1; tick(); clear_in();
    check("R8 go_slow override", mode, 0);

    // R7: memory-full without a valid sample, in every mode
    for (int m = 0; m < 4; m++) begin
      reach(m);
      mem_full = 1'b1; tick(); mem_full = 1'b0;
      check("R7 mem_full alone", mode, exp_mode(m, 0, 100, 200, 0, 1, 0, 0));
    end

    // main sweep: each threshold pair, start mode, value, with and without mem_full
    for (int t = 0; t < 6; t++) begin
      pb_thresh = pbs[t][7:0]; wb_thresh = wbs[t][7:0];
      for (int m = 0; m < 4; m++) begin
        for (int ev = 0; ev < 256; ev++) begin
          for (int mf = 0; mf < 2; mf++) begin
            reach(m);
            eval_val = ev[7:0]; eval_vld = 1'b1; mem_full = mf[0];
            tick(); clear_in();
            check(req_of(m, mf[0]), mode,
                  exp_mode(m, ev, pbs[t], wbs[t], 1, mf[0], 0, 0));
          end
        end
      end
    end

    // R10: one level per edge when climbing from fast with a huge value
    pb_thresh = 8'd10; wb_thresh = 8'd20;
    reach(1);
    eval_val = 8'd255; eval_vld = 1'b1; tick(); eval_vld = 1'b0;
    check("R10 single step", mode, 2);

    // R1: asynchronous reset from wave burst
    reach(3);
    @(posedge clk); #3; rst_n = 1'b0; #2;
    check("R1 async reset", mode, 0);
    tick(); rst_n = 1'b1;
    repeat (3) tick();
    check("R1 held after re-release", mode, 0);

    finish_run();
  end
endmodule